// File: doc/BRIEF.md
# DCO Control Word Loop Filter

This block is the digital loop filter of an on-chip clock generator. It holds a 12-bit oscillator control word. The upper 4 bits are a divider field and the lower 8 bits are a stage field. Both fields go to a digitally controlled oscillator.

A frequency comparator reports how far the base clock is from its nominal rate. It does so as a magnitude band code plus a direction bit, qualified by a one-cycle update strobe. On each strobe the filter nudges the control word by a fine, medium or coarse step:

- Subtracting raises the oscillator frequency.
- Adding lowers it.

The word wraps modulo 4096 and does not saturate. Divider codes above 9 are presented to the oscillator as 9, the slowest setting. A word that has run above the valid top value of 0x9FF therefore still yields a usable clock. It comes back through ordinary subtract steps.

A stable flag tells a clock monitor that the last measured error was in the finest band, within about five percent of nominal.

Top module: `dco_loop_filter`

## Requirements
- R1: While `rst` is high at a rising clock edge, the control word `{div_raw,stg_raw}` loads `RESET_WORD` (default 0x500) and `filt_stable` clears to 0. Both are visible after that edge.
- R2: At an edge where `upd` is 0, `div_raw`, `stg_raw` and `filt_stable` keep their values, whatever `err_mag` and `err_slow` are.
- R3: At an edge where `upd` is 1 and `err_mag` is 0 (fine band, error below 5 %), the word moves by 1 and `filt_stable` becomes 1.
- R4: At an edge where `upd` is 1 and `err_mag` is 1 (error 5 % to 15 %), the word moves by 8 and `filt_stable` becomes 0.
- R5: At an edge where `upd` is 1 and `err_mag` is 2 to 7 (error beyond 15 %), the word moves by 32 and `filt_stable` becomes 0.
- R6: The direction bit sets the sign of the step. `err_slow` = 1 means the base clock is slow and the step is subtracted. `err_slow` = 0 means it is fast and the step is added.
- R7: Steps use whole 12-bit arithmetic. A carry out of the stage field increments the divider field, and a borrow from it decrements the divider field.
- R8: The word wraps modulo 4096: 0xFFF + 1 gives 0x000 and 0x000 − 1 gives 0xFFF.
- R9: `div_eff` equals `div_raw` when `div_raw` is 9 or less, and equals 9 when `div_raw` is 0xA to 0xF. It follows `div_raw` with no added cycle.
- R10: `filt_stable` changes only on an update strobe or a reset, and holds its value between strobes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| upd | input | 1 | One-cycle strobe that qualifies the error code |
| err_mag | input | 3 | Error magnitude band: 0 fine, 1 medium, 2 to 7 coarse |
| err_slow | input | 1 | 1: base clock below nominal (subtract); 0: above (add) |
| div_raw | output | 4 | Raw divider field, bits 11:8 of the word |
| stg_raw | output | 8 | Stage field, bits 7:0 of the word |
| div_eff | output | 4 | Divider value for the oscillator, limited to 9 |
| filt_stable | output | 1 | Last strobe reported an error in the fine band |

## Verification
The word and the stable flag are registered. A strobe or reset applied before a rising edge is visible right after that edge, which is one cycle later. `div_eff` is combinational on the registered divider and so is valid in the same cycle as `div_raw`. The bench changes inputs and compares every output at falling edges. Each check therefore sees the result of exactly the one rising edge since the last stimulus, against a model advanced at that same edge.

// File: rtl/dlf_pkg.sv
package dlf_pkg;

   typedef enum logic [1:0] {
      STEP_FINE   = 2'd0,
      STEP_MID    = 2'd1,
      STEP_COARSE = 2'd2
   } step_cls_e;

   // Map a magnitude band code to its step class; every code above the
   // medium band selects the coarse step.
   function automatic step_cls_e classify(input logic [2:0] mag);
      if (mag == 3'd0)      return STEP_FINE;
      else if (mag == 3'd1) return STEP_MID;
      else                  return STEP_COARSE;
   endfunction

endpackage

// File: rtl/dlf_step_sel.sv
module dlf_step_sel #(
   parameter int CTRL_W      = 12,
   parameter int BAND_W      = 3,
   parameter int FINE_STEP   = 1,
   parameter int MID_STEP    = 8,
   parameter int COARSE_STEP = 32
) (
   input  logic [BAND_W-1:0] mag,
   input  logic              slow,
   output logic [CTRL_W-1:0] addend,
   output logic              fine
);
   import dlf_pkg::*;

   if (BAND_W != 3) begin : g_bad_band
      $error("dlf_step_sel: BAND_W must be 3");
   end
   if (COARSE_STEP >= (1 << (CTRL_W - 1))) begin : g_bad_step
      $error("dlf_step_sel: coarse step too large for the control word");
   end

   localparam logic [CTRL_W-1:0] FINE_V   = CTRL_W'(FINE_STEP);
   localparam logic [CTRL_W-1:0] MID_V    = CTRL_W'(MID_STEP);
   localparam logic [CTRL_W-1:0] COARSE_V = CTRL_W'(COARSE_STEP);

   step_cls_e         cls;
   logic [CTRL_W-1:0] size;

   always_comb begin
      cls = classify(mag);
      unique case (cls)
         STEP_FINE: size = FINE_V;
         STEP_MID:  size = MID_V;
         default:   size = COARSE_V;
      endcase
      // two's complement addend: subtraction wraps the same way as addition
      addend = slow ? (~size + CTRL_W'(1)) : size;
      fine   = (cls == STEP_FINE);
   end

endmodule

// File: rtl/dlf_word_reg.sv
module dlf_word_reg #(
   parameter int                  CTRL_W     = 12,
   parameter logic [CTRL_W-1:0]   RESET_WORD = 12'h500
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              upd,
   input  logic [CTRL_W-1:0] addend,
   input  logic              fine,
   output logic [CTRL_W-1:0] word,
   output logic              stable
);

   logic [CTRL_W-1:0] word_q;
   logic              stable_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         word_q   <= RESET_WORD;
         stable_q <= 1'b0;
      end else if (upd) begin
         word_q   <= word_q + addend;
         stable_q <= fine;
      end
   end

   assign word   = word_q;
   assign stable = stable_q;

endmodule

// File: rtl/dlf_div_limit.sv
module dlf_div_limit #(
   parameter int DIV_W   = 4,
   parameter int MAX_DIV = 9
) (
   input  logic [DIV_W-1:0] div_in,
   output logic [DIV_W-1:0] div_out
);

   localparam int FULL = (1 << DIV_W) - 1;

   if (MAX_DIV < 0 || MAX_DIV > FULL) begin : g_bad_max
      $error("dlf_div_limit: MAX_DIV outside the divider field range");
   end

   if (MAX_DIV == FULL) begin : g_pass
      assign div_out = div_in;
   end else begin : g_limit
      localparam logic [DIV_W-1:0] LIM = DIV_W'(MAX_DIV);
      assign div_out = (div_in > LIM) ? LIM : div_in;
   end

endmodule

// File: rtl/dco_loop_filter.sv
module dco_loop_filter #(
   parameter int                          DIV_W       = 4,
   parameter int                          STG_W       = 8,
   parameter int                          BAND_W      = 3,
   parameter int                          MAX_DIV     = 9,
   parameter int                          FINE_STEP   = 1,
   parameter int                          MID_STEP    = 8,
   parameter int                          COARSE_STEP = 32,
   parameter logic [DIV_W+STG_W-1:0]      RESET_WORD  = 12'h500
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              upd,
   input  logic [BAND_W-1:0] err_mag,
   input  logic              err_slow,
   output logic [DIV_W-1:0]  div_raw,
   output logic [STG_W-1:0]  stg_raw,
   output logic [DIV_W-1:0]  div_eff,
   output logic              filt_stable
);

   localparam int CTRL_W = DIV_W + STG_W;

   if (DIV_W < 1 || STG_W < 1) begin : g_bad_width
      $error("dco_loop_filter: field widths must be positive");
   end

   logic [CTRL_W-1:0] addend;
   logic              fine;
   logic [CTRL_W-1:0] word;

   dlf_step_sel #(
      .CTRL_W(CTRL_W), .BAND_W(BAND_W), .FINE_STEP(FINE_STEP),
      .MID_STEP(MID_STEP), .COARSE_STEP(COARSE_STEP)
   ) u_step (
      .mag(err_mag), .slow(err_slow), .addend(addend), .fine(fine)
   );

   dlf_word_reg #(
      .CTRL_W(CTRL_W), .RESET_WORD(RESET_WORD)
   ) u_reg (
      .clk(clk), .rst(rst), .upd(upd), .addend(addend), .fine(fine),
      .word(word), .stable(filt_stable)
   );

   assign div_raw = word[CTRL_W-1:STG_W];
   assign stg_raw = word[STG_W-1:0];

   dlf_div_limit #(
      .DIV_W(DIV_W), .MAX_DIV(MAX_DIV)
   ) u_lim (
      .div_in(div_raw), .div_out(div_eff)
   );

endmodule

// File: rtl/dlf_checker.sv
module dlf_checker #(
   parameter int                     DIV_W      = 4,
   parameter int                     STG_W      = 8,
   parameter int                     BAND_W     = 3,
   parameter int                     MAX_DIV    = 9,
   parameter logic [DIV_W+STG_W-1:0] RESET_WORD = 12'h500
) (
   input logic              clk,
   input logic              rst,
   input logic              upd,
   input logic [BAND_W-1:0] err_mag,
   input logic              err_slow,
   input logic [DIV_W-1:0]  div_raw,
   input logic [STG_W-1:0]  stg_raw,
   input logic [DIV_W-1:0]  div_eff,
   input logic              filt_stable
);
   localparam int CTRL_W = DIV_W + STG_W;
   localparam logic [DIV_W-1:0] LIM = DIV_W'(MAX_DIV);

   logic [CTRL_W-1:0] w;
   assign w = {div_raw, stg_raw};

   // R1
   a_r1_reset: assert property (@(posedge clk)
      rst |=> (w == RESET_WORD) && !filt_stable);

   // R2, R10
   a_r2_hold: assert property (@(posedge clk) disable iff (rst)
      !upd |=> $stable(w) && $stable(filt_stable));

   // R3, R6
   a_r3_fine_step: assert property (@(posedge clk) disable iff (rst)
      (upd && err_mag == 0) |=> filt_stable &&
      (w == ($past(err_slow) ? $past(w) - CTRL_W'(1) : $past(w) + CTRL_W'(1))));

   // R4
   a_r4_mid_step: assert property (@(posedge clk) disable iff (rst)
      (upd && err_mag == 1) |=> !filt_stable &&
      (w == ($past(err_slow) ? $past(w) - CTRL_W'(8) : $past(w) + CTRL_W'(8))));

   // R5
   a_r5_coarse_step: assert property (@(posedge clk) disable iff (rst)
      (upd && err_mag >= 2) |=> !filt_stable &&
      (w == ($past(err_slow) ? $past(w) - CTRL_W'(32) : $past(w) + CTRL_W'(32))));

   // R9
   a_r9_div_limit: assert property (@(posedge clk) disable iff (rst)
      (div_eff <= LIM) && ((div_raw <= LIM) ? (div_eff == div_raw) : (div_eff == LIM)));

endmodule

bind dco_loop_filter dlf_checker #(
   .DIV_W(DIV_W), .STG_W(STG_W), .BAND_W(BAND_W),
   .MAX_DIV(MAX_DIV), .RESET_WORD(RESET_WORD)
) u_chk (
   .clk(clk), .rst(rst), .upd(upd), .err_mag(err_mag), .err_slow(err_slow),
   .div_raw(div_raw), .stg_raw(stg_raw), .div_eff(div_eff),
   .filt_stable(filt_stable)
);

// File: tb/dco_loop_filter_test.sv
`timescale 1ns/1ps
module dco_loop_filter_test;

   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic       upd = 1'b0;
   logic [2:0] err_mag = 3'd0;
   logic       err_slow = 1'b0;
   logic [3:0] div_raw, div_eff;
   logic [7:0] stg_raw;
   logic       filt_stable;

   int checks = 0;
   int errors = 0;
   bit done = 0;

   logic [11:0] m_word = 12'h500;
   logic        m_stab = 1'b0;

   always #2.5 clk = ~clk;

   dco_loop_filter uut (
      .clk(clk), .rst(rst), .upd(upd), .err_mag(err_mag), .err_slow(err_slow),
      .div_raw(div_raw), .stg_raw(stg_raw), .div_eff(div_eff),
      .filt_stable(filt_stable)
   );

   function automatic logic [11:0] next_word(logic [11:0] w, logic [2:0] mag, logic slow);
      logic [11:0] s;
      s = (mag == 3'd0) ? 12'd1 : (mag == 3'd1) ? 12'd8 : 12'd32;
      return slow ? w - s : w + s;
   endfunction

   function automatic logic [3:0] lim_div(logic [3:0] d);
      return (d > 4'd9) ? 4'd9 : d;
   endfunction

   task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   task automatic check_all(string tag);
      chk(tag, {20'd0, div_raw, stg_raw}, {20'd0, m_word});
      chk((tag == "R2") ? "R10" : tag, {31'd0, filt_stable}, {31'd0, m_stab});
      chk("R9", {28'd0, div_eff}, {28'd0, lim_div(m_word[11:8])});
   endtask

   // one cycle: drive at falling edge, model at rising edge, check at next falling edge
   task automatic cyc(logic u, logic [2:0] mag, logic slow, string tag);
      upd = u; err_mag = mag; err_slow = slow;
      @(posedge clk);
      if (u) begin
         m_word = next_word(m_word, mag, slow);
         m_stab = (mag == 3'd0);
      end
      @(negedge clk);
      upd = 1'b0;
      check_all(tag);
   endtask

   initial begin
      #(200000 * 5.0);
      if (!done) begin
         errors++;
         $display("FAIL watchdog: actual hung expected finish");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      int seed;
      seed = $urandom(32'h5eed1234);
      repeat (3) @(negedge clk);
      rst = 1'b0;
      m_word = 12'h500; m_stab = 1'b0;
      check_all("R1");

      // R2: no strobe, inputs wiggle
      for (int i = 0; i < 6; i++) cyc(1'b0, 3'(i), i[0], "R2");
      // R3 with R6 direction
      cyc(1'b1, 3'd0, 1'b0, "R3");
      cyc(1'b1, 3'd0, 1'b1, "R6");
      // R10: stable held between strobes
      cyc(1'b1, 3'd0, 1'b0, "R3");
      for (int i = 0; i < 4; i++) cyc(1'b0, 3'd5, 1'b1, "R2");
      cyc(1'b1, 3'd1, 1'b0, "R4");
      cyc(1'b1, 3'd1, 1'b1, "R4");
      cyc(1'b1, 3'd2, 1'b0, "R5");
      cyc(1'b1, 3'd7, 1'b1, "R5");
      // R7: word is 0x501 here; borrow then carry across the stage field
      cyc(1'b1, 3'd0, 1'b1, "R3");
      cyc(1'b1, 3'd0, 1'b1, "R7");
      chk("R7", {28'd0, div_raw}, 32'd4);
      cyc(1'b1, 3'd0, 1'b0, "R7");
      chk("R7", {24'd0, stg_raw}, 32'd0);
      // climb past 0x9FF into the limited divider region and on to the wrap
      while (m_word != 12'hFE0) begin
         cyc(1'b1, 3'd3, 1'b0, "R9");
      end
      chk("R9", {28'd0, div_eff}, 32'd9);
      cyc(1'b1, 3'd4, 1'b0, "R8");
      chk("R8", {20'd0, div_raw, stg_raw}, 32'h000);
      cyc(1'b1, 3'd0, 1'b1, "R8");
      chk("R8", {20'd0, div_raw, stg_raw}, 32'hFFF);
      cyc(1'b1, 3'd0, 1'b0, "R8");
      // reset in mid-run
      rst = 1'b1;
      @(posedge clk); m_word = 12'h500; m_stab = 1'b0;
      @(negedge clk); rst = 1'b0;
      check_all("R1");

      // constrained random
      for (int i = 0; i < 3000; i++) begin
         logic u, s;
         logic [2:0] m;
         u = ($urandom % 2) == 0;
         m = 3'($urandom % 8);
         s = ($urandom % 2) == 0;
         cyc(u, m, s, !u ? "R2" : (m == 0) ? "R3" : (m == 1) ? "R4" : "R5");
      end

      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule